// File: doc/BRIEF.md
# External/Status Change Interrupt Latch

This block watches six external and status conditions of one serial channel: break/abort, transmit underrun/end-of-message, clear-to-send, sync/hunt, carrier detect and baud-counter zero count. Each condition is brought through a synchroniser. A status interrupt is raised when any condition whose enable is set changes level, rising or falling. Once raised, the interrupt freezes the status the software will read. The status stays frozen until software writes the dedicated reset command, so a short glitch on a line is still seen after the line has returned to its old level.

Software programs the block through a simple register write port with four addresses:

- the command register (address 0);
- a channel mode register (address 1), whose bit 0 is the channel's status-interrupt enable;
- the master interrupt control register (address 9), whose bit 3 is the master enable;
- the status-interrupt enable register (address 15).

The block presents the status byte and a pending flag. The pending flag feeds the chip-level interrupt-pending logic. The two flags for transmit buffer empty and receive character available are passed into the status byte unchanged.

Top module: `extStatusIrq`

## Requirements
- R1: After reset, with all inputs low, the status byte is 0x00 and the pending flag is low; all enables are cleared.
- R2: A write to address 15 sets the source enables from these data bits: 7 break, 6 underrun, 5 CTS, 4 sync, 3 DCD, 1 zero count. A write to address 1 sets the channel enable from bit 0. A write to address 9 sets the master enable from bit 3.
- R3: Status byte layout: bit 7 break, bit 6 underrun, bit 5 CTS, bit 4 sync, bit 3 DCD, bit 1 zero count. The external input vector orders them [5] break, [4] underrun, [3] CTS, [2] sync, [1] DCD, [0] zero count. While no interrupt is latched, each bit shows its input two clock edges after the input changes.
- R4: A rising or falling edge on an enabled source latches the interrupt. The latch is set on the third clock edge after the input change.
- R5: An edge on a source whose enable is clear never latches the interrupt, and that source's status bit keeps tracking its input live.
- R6: While the interrupt is latched, the status bits of enabled sources hold the values captured at the first change, and later edges on those sources are not reported.
- R7: Writing a value with bits 5:3 = 010 to address 0 clears the latch on that clock edge. Other command codes leave the latch set.
- R8: If a source differs from its captured value when the latch is cleared, the latch sets again one clock edge later, and the new value is captured.
- R9: The pending output is the latch gated by both the channel enable and the master enable. The latch itself still sets while either enable is off, and it appears at the output as soon as both enables are on.
- R10: Status bit 2 is the transmit-buffer-empty input and bit 0 is the receive-available input, whether or not the interrupt is latched.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 4 | Register address |
| wrData | input | 8 | Register write data |
| extIn | input | 6 | Asynchronous condition inputs: [5] break, [4] underrun, [3] CTS, [2] sync, [1] DCD, [0] zero count |
| txEmpty | input | 1 | Transmit buffer empty flag, already synchronous |
| rxAvail | input | 1 | Receive character available flag, already synchronous |
| rr0 | output | 8 | Status byte |
| stIrq | output | 1 | Status interrupt pending, gated by the enables |

## Verification
The bench samples each result at a fixed cycle offset from the stimulus. A missing or extra synchroniser stage therefore shows up as a status bit that changes one edge early or late. A capture register that fails to freeze shows up as a status bit that follows a later edge while the pending flag is still high. A latch that misses an edge, or that clears and loses a pending difference, leaves the pending flag low on the edge right after the reset command, where it should be high. Wrong enable decoding shows up within three edges as a pending flag that is raised or missing.

// File: rtl/esPkg.sv
package esPkg;
  localparam int ES_SRC = 6;

  typedef struct packed {
    logic              holdSnap;
    logic [ES_SRC-1:0] showMask;
  } esStrobe_t;
endpackage

// File: rtl/esDatapath.sv
module esDatapath
  import esPkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ES_SRC-1:0] extIn,
  input  logic              txEmpty,
  input  logic              rxAvail,
  input  esStrobe_t         strb,
  output logic [ES_SRC-1:0] chgVec,
  output logic [7:0]        rr0
);
  logic [ES_SRC-1:0] syncChain [SYNC_STAGES];
  logic [ES_SRC-1:0] syncQ;
  logic [ES_SRC-1:0] snapQ;
  logic [ES_SRC-1:0] shown;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncChain[0] <= '0;
    else       syncChain[0] <= extIn;
  end

  genvar gi;
  generate
    for (gi = 1; gi < SYNC_STAGES; gi++) begin : g_sync
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncChain[gi] <= '0;
        else       syncChain[gi] <= syncChain[gi-1];
      end
    end
  endgenerate

  assign syncQ = syncChain[SYNC_STAGES-1];

  // capture register follows the synchronised inputs until frozen
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              snapQ <= '0;
    else if (!strb.holdSnap) snapQ <= syncQ;
  end

  assign chgVec = syncQ ^ snapQ;
  assign shown  = (snapQ & strb.showMask) | (syncQ & ~strb.showMask);
  assign rr0    = {shown[5], shown[4], shown[3], shown[2], shown[1],
                   txEmpty, shown[0], rxAvail};
endmodule

// File: rtl/esControl.sv
module esControl
  import esPkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [7:0]        wrData,
  input  logic [ES_SRC-1:0] chgVec,
  output esStrobe_t         strb,
  output logic [ES_SRC-1:0] enMask,
  output logic              stIrq
);
  localparam logic [ADDR_W-1:0] A_CMD    = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_MODE   = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_MASTER = ADDR_W'(9);
  localparam logic [ADDR_W-1:0] A_SRCEN  = ADDR_W'(15);
  localparam logic [2:0]        CMD_CLR  = 3'b010;

  logic chanEnQ, masterEnQ, latchQ;
  logic clrCmd, setLatch;

  assign clrCmd   = wrEn && (wrAddr == A_CMD) && (wrData[5:3] == CMD_CLR);
  assign setLatch = !latchQ && |(chgVec & enMask);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enMask    <= '0;
      chanEnQ   <= 1'b0;
      masterEnQ <= 1'b0;
    end else if (wrEn) begin
      if (wrAddr == A_SRCEN)
        enMask <= {wrData[7], wrData[6], wrData[5], wrData[4], wrData[3], wrData[1]};
      if (wrAddr == A_MODE)   chanEnQ   <= wrData[0];
      if (wrAddr == A_MASTER) masterEnQ <= wrData[3];
    end
  end

  // a fresh change wins over a clear (set only occurs while unlatched)
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         latchQ <= 1'b0;
    else if (setLatch) latchQ <= 1'b1;
    else if (clrCmd)   latchQ <= 1'b0;
  end

  assign strb.holdSnap = latchQ;
  assign strb.showMask = latchQ ? enMask : '0;
  assign stIrq         = latchQ && chanEnQ && masterEnQ;
endmodule

// File: rtl/extStatusIrq.sv
module extStatusIrq
  import esPkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W      = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [7:0]        wrData,
  input  logic [ES_SRC-1:0] extIn,
  input  logic              txEmpty,
  input  logic              rxAvail,
  output logic [7:0]        rr0,
  output logic              stIrq
);
  esStrobe_t         strb;
  logic [ES_SRC-1:0] chgVec;
  logic [ES_SRC-1:0] enMask;

  esControl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .chgVec(chgVec), .strb(strb), .enMask(enMask), .stIrq(stIrq)
  );

  esDatapath #(.SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk(clk), .rstN(rstN), .extIn(extIn), .txEmpty(txEmpty),
    .rxAvail(rxAvail), .strb(strb), .chgVec(chgVec), .rr0(rr0)
  );
endmodule

// File: rtl/extStatusIrq_chk.sv
module extStatusIrq_chk
  import esPkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [3:0]        wrAddr,
  input logic [7:0]        wrData,
  input logic [7:0]        rr0,
  input logic              stIrq,
  input esStrobe_t         strb,
  input logic [ES_SRC-1:0] chgVec,
  input logic [ES_SRC-1:0] enMask
);
  logic       latched;
  logic       clrCmd;
  logic [7:0] heldBits;

  assign latched  = strb.holdSnap;
  assign clrCmd   = wrEn && (wrAddr == 4'd0) && (wrData[5:3] == 3'b010);
  assign heldBits = rr0 & {enMask[5], enMask[4], enMask[3], enMask[2], enMask[1],
                           1'b0, enMask[0], 1'b0};

  p_freeze_r6: assert property (@(posedge clk) disable iff (!rstN)
    (latched && !wrEn) |=> (heldBits == $past(heldBits)));

  p_clear_r7: assert property (@(posedge clk) disable iff (!rstN)
    (latched && clrCmd) |=> !latched);

  p_noset_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!latched && ((chgVec & enMask) == '0)) |=> !latched);

  p_cause_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(latched) |-> $past(|(chgVec & enMask)));

  p_gate_r9: assert property (@(posedge clk) disable iff (!rstN)
    stIrq |-> latched);
endmodule

bind extStatusIrq extStatusIrq_chk u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
  .rr0(rr0), .stIrq(stIrq), .strb(strb), .chgVec(chgVec), .enMask(enMask)
);

// File: tb/extStatusIrq_bench.sv
module extStatusIrq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 10;
  // {extIn[5:0], txEmpty, rxAvail, expected rr0}
  localparam logic [15:0] VEC [NVEC] = '{
    16'h80_80, 16'h40_40, 16'h20_20, 16'h10_10, 16'h08_08,
    16'h04_02, 16'h02_04, 16'h01_01, 16'hAF_AF, 16'h05_03
  };

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [3:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic [5:0] extIn = '0;
  logic       txEmpty = 1'b0;
  logic       rxAvail = 1'b0;
  logic [7:0] rr0;
  logic       stIrq;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  extStatusIrq u_extStatusIrq (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .extIn(extIn), .txEmpty(txEmpty), .rxAvail(rxAvail), .rr0(rr0), .stIrq(stIrq)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    tick(3);
    rstN = 1'b1;
    tick(1);
    chk("R1 status", rr0, 8'h00);
    chk("R1 pending", {7'd0, stIrq}, 8'h00);

    // R3 R10 live layout table, no enables set
    for (int i = 0; i < NVEC; i++) begin
      {extIn, txEmpty, rxAvail} = VEC[i][15:8];
      tick(2);
      chk("R3 R10 layout", rr0, VEC[i][7:0]);
      chk("R5 no irq without enables", {7'd0, stIrq}, 8'h00);
    end
    extIn = '0; txEmpty = 1'b0; rxAvail = 1'b0;
    tick(3);

    // R2 R4: CTS enable, rising edge
    wr(4'd15, 8'h20); wr(4'd1, 8'h01); wr(4'd9, 8'h08);
    extIn[3] = 1'b1;
    tick(2);
    chk("R4 not before third edge", {7'd0, stIrq}, 8'h00);
    tick(1);
    chk("R4 rising edge", {7'd0, stIrq}, 8'h01);
    chk("R3 cts bit", rr0, 8'h20);

    // R6 frozen, R5 disabled DCD stays live
    extIn[3] = 1'b0; extIn[1] = 1'b1;
    tick(3);
    chk("R6 cts held", rr0 & 8'h20, 8'h20);
    chk("R5 dcd live", rr0 & 8'h08, 8'h08);
    chk("R6 still pending", {7'd0, stIrq}, 8'h01);

    // R7 other command keeps latch
    wr(4'd0, 8'h28);
    chk("R7 other cmd", {7'd0, stIrq}, 8'h01);

    // R7 R8 clear with pending difference
    wr(4'd0, 8'h10);
    chk("R7 clear", {7'd0, stIrq}, 8'h00);
    tick(1);
    chk("R8 re-raise", {7'd0, stIrq}, 8'h01);
    chk("R8 new capture", rr0 & 8'h20, 8'h00);
    wr(4'd0, 8'h10);
    chk("R7 clear no diff", {7'd0, stIrq}, 8'h00);
    tick(1);
    chk("R8 stays low", {7'd0, stIrq}, 8'h00);

    // R4 falling edge
    extIn[3] = 1'b1; tick(3);
    wr(4'd0, 8'h10); tick(1);
    chk("R4 after rise cleared", {7'd0, stIrq}, 8'h00);
    extIn[3] = 1'b0; tick(3);
    chk("R4 falling edge", {7'd0, stIrq}, 8'h01);
    wr(4'd0, 8'h10);

    // R9 master gating
    wr(4'd9, 8'h00);
    extIn[3] = 1'b1; tick(3);
    chk("R9 master off", {7'd0, stIrq}, 8'h00);
    wr(4'd9, 8'h08);
    chk("R9 master on", {7'd0, stIrq}, 8'h01);
    wr(4'd0, 8'h10); tick(1);
    // R9 channel gating
    wr(4'd1, 8'h00);
    extIn[3] = 1'b0; tick(3);
    chk("R9 chan off", {7'd0, stIrq}, 8'h00);
    wr(4'd1, 8'h01);
    chk("R9 chan on", {7'd0, stIrq}, 8'h01);
    wr(4'd0, 8'h10); tick(1);

    // R5 disabled DCD edge
    extIn[1] = 1'b0; tick(4);
    chk("R5 dcd edge ignored", {7'd0, stIrq}, 8'h00);
    chk("R5 dcd bit live", rr0 & 8'h08, 8'h00);

    // R2 zero-count enable at bit 1
    wr(4'd15, 8'h02);
    extIn[0] = 1'b1; tick(3);
    chk("R2 zero count irq", {7'd0, stIrq}, 8'h01);
    chk("R3 zero count bit", rr0 & 8'h02, 8'h02);
    wr(4'd0, 8'h10); tick(1);
    chk("R8 no diff after clear", {7'd0, stIrq}, 8'h00);
    extIn[0] = 1'b0; tick(3);
    chk("R4 zero count fall", {7'd0, stIrq}, 8'h01);
    wr(4'd0, 8'h10); tick(1);

    // R2 break enable at bit 7, R10 while latched
    wr(4'd15, 8'h80);
    extIn[5] = 1'b1; tick(3);
    chk("R2 break irq", {7'd0, stIrq}, 8'h01);
    txEmpty = 1'b1; rxAvail = 1'b1; tick(1);
    chk("R10 flags while latched", rr0, 8'h85);
    wr(4'd0, 8'h10); tick(1);
    chk("R7 break cleared", {7'd0, stIrq}, 8'h00);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule